// File: doc/BRIEF.md
# DMA Channel Status and Interrupt Logic

This block keeps the status word and drives the interrupt lines of one channel of a DMA engine that walks a linked list of descriptors. The descriptor engine reports events as single-cycle pulses: a descriptor finished with its byte count at zero, a re-read of the last descriptor came back, or one of six error conditions occurred. Along with these pulses it presents the next-descriptor pointer, the resume request and the current descriptor's interrupt-enable and status-write-back-enable bits. The block turns these events into sticky status bits, level interrupt lines, a channel-active flag, a request to re-read the last descriptor and a request to write status back to memory.

A completion sets a flag only when the descriptor asked for interrupts and no error came with it. Errors always set a flag and always interrupt. The two zero-result-check errors are the exception: when status write-back is enabled they go to a memory write-back request instead of the register. When resume is asserted as the last descriptor finishes, the block marks end-of-transfer, keeps the channel active and asks for the descriptor to be read again. If that re-read still shows a null pointer, the chain ends. Software clears status bits by writing ones.

Top module: `chs_channel_status`

## Requirements
- R1: A `desc_done_i` pulse while active, with no error pulse in that cycle, `desc_irq_en_i`=1, and either `next_ptr_i`≠0 or `resume_i`=1, sets status bit 0 (end-of-transfer). The channel stays active.
- R2: A `desc_done_i` pulse while active, with no error, `next_ptr_i`=0 and `resume_i`=0, clears `active_o`. If `desc_irq_en_i`=1 it also sets status bit 1 (end-of-chain).
- R3: When `desc_irq_en_i`=0, a completion or re-read event sets neither status bit 0 nor status bit 1. The effect on `active_o` is unchanged.
- R4: An error pulse that is recorded in the register suppresses completion flags in the same cycle and clears `active_o`.
- R5: Each error pulse sets its own status bit, whatever the interrupt enable, and several may be set in one cycle: parity error bit 2, master abort bit 3, target abort bit 4, memory-port abort bit 5.
- R6: A `desc_done_i` with `next_ptr_i`=0 and `resume_i`=1 while active and error-free pulses `reread_o` for one cycle. A later `reread_done_i` with `next_ptr_i`=0 sets bits 0 and 1 (when `desc_irq_en_i`=1) and clears `active_o`. With a non-null pointer it changes nothing.
- R7: With `desc_wb_en_i`=0, zero-result errors P and Q set status bits 6 and 7. With `desc_wb_en_i`=1 they instead pulse `wb_req_o` with `wb_stat_o` = {1 (transfer complete), Q, P}, set no bit, raise no interrupt and leave `active_o` unchanged.
- R8: An error that arrives while end-of-transfer is still set leaves bit 0 set and adds its error bit.
- R9: Status bits are sticky. Writing `sw_clr_we_i`=1 clears each bit that is 1 in `sw_clr_data_i`. A set and a clear of the same bit in one cycle leave the bit set.
- R10: `irq_eot_o` equals bit 0, `irq_eoc_o` equals bit 1, and `irq_err_o` is the OR of bits 2 to 7.
- R11: Reset clears all outputs. `chan_start_i` sets `active_o` when inactive.
- R12: `desc_done_i` and `reread_done_i` are ignored while the channel is inactive.
- R13: Every output changes at the first clock edge after the event that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_start_i | input | 1 | Channel enable pulse |
| desc_done_i | input | 1 | Descriptor finished, byte count zero |
| reread_done_i | input | 1 | Re-read of last descriptor returned |
| next_ptr_i | input | PTR_W | Next-descriptor pointer, 0 is null |
| resume_i | input | 1 | Resume request bit |
| desc_irq_en_i | input | 1 | Descriptor interrupt enable |
| desc_wb_en_i | input | 1 | Descriptor status write-back enable |
| err_parity_i | input | 1 | Internal interface parity error pulse |
| err_mabort_i | input | 1 | Internal bus master abort pulse |
| err_tabort_i | input | 1 | Internal bus target abort pulse |
| err_mport_i | input | 1 | Memory port abort pulse |
| err_zr_p_i | input | 1 | Zero-result check error, P buffer |
| err_zr_q_i | input | 1 | Zero-result check error, Q buffer |
| sw_clr_we_i | input | 1 | Software clear strobe |
| sw_clr_data_i | input | 8 | Write-one-to-clear mask |
| active_o | output | 1 | Channel active |
| status_o | output | 8 | Sticky status word |
| irq_eot_o | output | 1 | End-of-transfer interrupt |
| irq_eoc_o | output | 1 | End-of-chain interrupt |
| irq_err_o | output | 1 | Error interrupt |
| reread_o | output | 1 | Re-read last descriptor request |
| wb_req_o | output | 1 | Status write-back request |
| wb_stat_o | output | 3 | Write-back status {complete, Q err, P err} |

## Verification
The bench targets these corner cases:
- Resume arriving on the final descriptor. A design that ends the chain at once would drop `active_o` and raise end-of-chain one event early.
- Completion with interrupt enable clear. A design that ignores the enable would set flags that software never asked for.
- An error pulse together with a completion. A design that gets this wrong reports a clean end-of-transfer alongside the error.
- Zero-result errors with write-back enabled. A design that misroutes them interrupts instead of requesting a write-back.
- A software clear landing in the same cycle as a new event. A design that gets this wrong loses an interrupt.
- Descriptor events while the channel is idle. A design that does not ignore them sets flags without a transfer running.

// File: rtl/chs_pkg.sv
package chs_pkg;
  localparam int ST_W   = 8;
  localparam int ST_EOT = 0;
  localparam int ST_EOC = 1;
  localparam int ST_PAR = 2;
  localparam int ST_MAB = 3;
  localparam int ST_TAB = 4;
  localparam int ST_MPA = 5;
  localparam int ST_ZRP = 6;
  localparam int ST_ZRQ = 7;
  localparam int WB_W   = 3;

  typedef struct packed {
    logic zr_q;
    logic zr_p;
    logic mport;
    logic tabort;
    logic mabort;
    logic parity;
  } chs_err_t;
endpackage

// File: rtl/chs_event_decode.sv
module chs_event_decode
  import chs_pkg::*;
#(
  parameter int PTR_W = 32
) (
  input  logic             active,
  input  logic             desc_done,
  input  logic             reread_done,
  input  logic [PTR_W-1:0] next_ptr,
  input  logic             resume,
  input  logic             irq_en,
  input  logic             wb_en,
  input  chs_err_t         err,
  output logic [ST_W-1:0]  set_vec,
  output logic             go_idle,
  output logic             reread_req,
  output logic             wb_req,
  output logic [WB_W-1:0]  wb_stat
);
  logic ptr_null;
  logic zr_to_reg;
  logic any_reg_err;
  logic done_ok;
  logic reread_ok;
  logic chain_end;
  logic eot_evt;
  logic eoc_evt;

  assign ptr_null    = (next_ptr == '0);
  assign zr_to_reg   = !wb_en;
  assign any_reg_err = err.parity | err.mabort | err.tabort | err.mport |
                       (zr_to_reg & (err.zr_p | err.zr_q));
  assign done_ok     = active & desc_done & !any_reg_err;
  assign reread_ok   = active & reread_done & !any_reg_err;

  always_comb begin
    eot_evt    = 1'b0;
    eoc_evt    = 1'b0;
    chain_end  = 1'b0;
    reread_req = 1'b0;
    if (done_ok) begin
      if (!ptr_null || resume) begin
        eot_evt    = 1'b1;
        reread_req = ptr_null;
      end else begin
        eoc_evt    = 1'b1;
        chain_end  = 1'b1;
      end
    end else if (reread_ok && ptr_null) begin
      eot_evt   = 1'b1;
      eoc_evt   = 1'b1;
      chain_end = 1'b1;
    end
  end

  always_comb begin
    set_vec         = '0;
    set_vec[ST_EOT] = eot_evt & irq_en;
    set_vec[ST_EOC] = eoc_evt & irq_en;
    set_vec[ST_PAR] = err.parity;
    set_vec[ST_MAB] = err.mabort;
    set_vec[ST_TAB] = err.tabort;
    set_vec[ST_MPA] = err.mport;
    set_vec[ST_ZRP] = err.zr_p & zr_to_reg;
    set_vec[ST_ZRQ] = err.zr_q & zr_to_reg;
  end

  assign go_idle = active & (chain_end | any_reg_err);
  assign wb_req  = wb_en & (err.zr_p | err.zr_q);
  assign wb_stat = {1'b1, err.zr_q, err.zr_p};
endmodule

// File: rtl/chs_status_reg.sv
module chs_status_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_vec,
  input  logic         clr_we,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] st_q,
  output logic [W-1:0] st_nxt
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic clr_bit;
    assign clr_bit   = clr_we & clr_mask[i];
    assign st_nxt[i] = set_vec[i] | (st_q[i] & !clr_bit);
    always_ff @(posedge clk) begin
      if (rst) st_q[i] <= 1'b0;
      else     st_q[i] <= st_nxt[i];
    end
  end
endmodule

// File: rtl/chs_irq_out.sv
module chs_irq_out
  import chs_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [ST_W-1:0] st_nxt,
  output logic            irq_eot,
  output logic            irq_eoc,
  output logic            irq_err
);
  localparam logic [ST_W-1:0] ERR_MASK = ~((ST_W'(1) << ST_EOT) | (ST_W'(1) << ST_EOC));

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_eot <= 1'b0;
      irq_eoc <= 1'b0;
      irq_err <= 1'b0;
    end else begin
      irq_eot <= st_nxt[ST_EOT];
      irq_eoc <= st_nxt[ST_EOC];
      irq_err <= |(st_nxt & ERR_MASK);
    end
  end
endmodule

// File: rtl/chs_channel_status.sv
module chs_channel_status
  import chs_pkg::*;
#(
  parameter int PTR_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chan_start_i,
  input  logic             desc_done_i,
  input  logic             reread_done_i,
  input  logic [PTR_W-1:0] next_ptr_i,
  input  logic             resume_i,
  input  logic             desc_irq_en_i,
  input  logic             desc_wb_en_i,
  input  logic             err_parity_i,
  input  logic             err_mabort_i,
  input  logic             err_tabort_i,
  input  logic             err_mport_i,
  input  logic             err_zr_p_i,
  input  logic             err_zr_q_i,
  input  logic             sw_clr_we_i,
  input  logic [ST_W-1:0]  sw_clr_data_i,
  output logic             active_o,
  output logic [ST_W-1:0]  status_o,
  output logic             irq_eot_o,
  output logic             irq_eoc_o,
  output logic             irq_err_o,
  output logic             reread_o,
  output logic             wb_req_o,
  output logic [WB_W-1:0]  wb_stat_o
);
  chs_err_t        err;
  logic [ST_W-1:0] set_vec;
  logic [ST_W-1:0] st_nxt;
  logic            go_idle;
  logic            reread_req;
  logic            wb_req;
  logic [WB_W-1:0] wb_stat;

  assign err = '{zr_q: err_zr_q_i, zr_p: err_zr_p_i, mport: err_mport_i,
                 tabort: err_tabort_i, mabort: err_mabort_i, parity: err_parity_i};

  chs_event_decode #(.PTR_W(PTR_W)) dec_i (
    .active      (active_o),
    .desc_done   (desc_done_i),
    .reread_done (reread_done_i),
    .next_ptr    (next_ptr_i),
    .resume      (resume_i),
    .irq_en      (desc_irq_en_i),
    .wb_en       (desc_wb_en_i),
    .err         (err),
    .set_vec     (set_vec),
    .go_idle     (go_idle),
    .reread_req  (reread_req),
    .wb_req      (wb_req),
    .wb_stat     (wb_stat)
  );

  chs_status_reg #(.W(ST_W)) st_i (
    .clk      (clk),
    .rst      (rst),
    .set_vec  (set_vec),
    .clr_we   (sw_clr_we_i),
    .clr_mask (sw_clr_data_i),
    .st_q     (status_o),
    .st_nxt   (st_nxt)
  );

  chs_irq_out irq_i (
    .clk     (clk),
    .rst     (rst),
    .st_nxt  (st_nxt),
    .irq_eot (irq_eot_o),
    .irq_eoc (irq_eoc_o),
    .irq_err (irq_err_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active_o  <= 1'b0;
      reread_o  <= 1'b0;
      wb_req_o  <= 1'b0;
      wb_stat_o <= '0;
    end else begin
      if (!active_o && chan_start_i) active_o <= 1'b1;
      else if (go_idle)              active_o <= 1'b0;
      reread_o  <= reread_req;
      wb_req_o  <= wb_req;
      wb_stat_o <= wb_req ? wb_stat : '0;
    end
  end
endmodule

// File: rtl/chs_channel_status_chk.sv
module chs_channel_status_chk
  import chs_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            desc_done_i,
  input logic            reread_done_i,
  input logic            desc_irq_en_i,
  input logic            desc_wb_en_i,
  input logic            err_parity_i,
  input logic            err_mabort_i,
  input logic            err_tabort_i,
  input logic            err_mport_i,
  input logic            err_zr_p_i,
  input logic            err_zr_q_i,
  input logic            sw_clr_we_i,
  input logic [ST_W-1:0] sw_clr_data_i,
  input logic            active_o,
  input logic [ST_W-1:0] status_o,
  input logic            irq_eot_o,
  input logic            irq_eoc_o,
  input logic            irq_err_o,
  input logic            wb_req_o,
  input logic [WB_W-1:0] wb_stat_o
);
  p_no_eot_without_ie_r3: assert property (@(posedge clk) disable iff (rst)
    (desc_done_i && !reread_done_i && !desc_irq_en_i && !status_o[ST_EOT]) |=> !status_o[ST_EOT]);

  p_eoc_goes_idle_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(status_o[ST_EOC]) |-> !active_o);

  p_err_irq_r5: assert property (@(posedge clk) disable iff (rst)
    (err_parity_i || err_mabort_i || err_tabort_i || err_mport_i) |=> irq_err_o);

  p_zr_writeback_r7: assert property (@(posedge clk) disable iff (rst)
    ((err_zr_p_i || err_zr_q_i) && desc_wb_en_i) |=> (wb_req_o && wb_stat_o[WB_W-1]));

  p_irq_level_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> (irq_eot_o == status_o[ST_EOT] && irq_eoc_o == status_o[ST_EOC] &&
              irq_err_o == (|status_o[ST_W-1:ST_PAR])));

  p_set_beats_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (sw_clr_we_i && sw_clr_data_i[ST_PAR] && err_parity_i) |=> status_o[ST_PAR]);
endmodule

bind chs_channel_status chs_channel_status_chk chk_i (
  .clk           (clk),
  .rst           (rst),
  .desc_done_i   (desc_done_i),
  .reread_done_i (reread_done_i),
  .desc_irq_en_i (desc_irq_en_i),
  .desc_wb_en_i  (desc_wb_en_i),
  .err_parity_i  (err_parity_i),
  .err_mabort_i  (err_mabort_i),
  .err_tabort_i  (err_tabort_i),
  .err_mport_i   (err_mport_i),
  .err_zr_p_i    (err_zr_p_i),
  .err_zr_q_i    (err_zr_q_i),
  .sw_clr_we_i   (sw_clr_we_i),
  .sw_clr_data_i (sw_clr_data_i),
  .active_o      (active_o),
  .status_o      (status_o),
  .irq_eot_o     (irq_eot_o),
  .irq_eoc_o     (irq_eoc_o),
  .irq_err_o     (irq_err_o),
  .wb_req_o      (wb_req_o),
  .wb_stat_o     (wb_stat_o)
);

// File: tb/chs_channel_status_tb.sv
module chs_channel_status_tb_top;
  localparam int PW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          chan_start_i = 0, desc_done_i = 0, reread_done_i = 0;
  logic [PW-1:0] next_ptr_i = '0;
  logic          resume_i = 0, desc_irq_en_i = 0, desc_wb_en_i = 0;
  logic          err_parity_i = 0, err_mabort_i = 0, err_tabort_i = 0, err_mport_i = 0;
  logic          err_zr_p_i = 0, err_zr_q_i = 0;
  logic          sw_clr_we_i = 0;
  logic [7:0]    sw_clr_data_i = '0;
  logic          active_o, irq_eot_o, irq_eoc_o, irq_err_o, reread_o, wb_req_o;
  logic [7:0]    status_o;
  logic [2:0]    wb_stat_o;

  int n_chk = 0, n_fail = 0;
  string scen = "R11";

  // reference model state
  bit       m_act;
  bit [7:0] m_st;
  bit       m_rr, m_wb;
  bit [2:0] m_wbs;

  always #2 clk = ~clk;

  chs_channel_status #(.PTR_W(PW)) dut_i (.*);

  always @(posedge clk) begin
    bit zr_reg, anyerr, ending, eot, eoc, act_n;
    bit [7:0] set;
    if (rst) begin
      m_act = 0; m_st = 0; m_rr = 0; m_wb = 0; m_wbs = 0;
    end else begin
      zr_reg = !desc_wb_en_i;
      set = 0;
      set[2] = err_parity_i; set[3] = err_mabort_i;
      set[4] = err_tabort_i; set[5] = err_mport_i;
      set[6] = err_zr_p_i && zr_reg; set[7] = err_zr_q_i && zr_reg;
      anyerr = (set[7:2] != 0);
      eot = 0; eoc = 0; ending = 0; m_rr = 0;
      if (m_act && !anyerr && desc_done_i) begin
        if (next_ptr_i != 0 || resume_i) begin
          eot = 1;
          if (next_ptr_i == 0) m_rr = 1;
        end else begin
          eoc = 1; ending = 1;
        end
      end else if (m_act && !anyerr && reread_done_i && next_ptr_i == 0) begin
        eot = 1; eoc = 1; ending = 1;
      end
      set[0] = eot && desc_irq_en_i;
      set[1] = eoc && desc_irq_en_i;
      act_n = m_act;
      if (!m_act && chan_start_i) act_n = 1;
      else if (m_act && (ending || anyerr)) act_n = 0;
      m_act = act_n;
      m_st = (sw_clr_we_i ? (m_st & ~sw_clr_data_i) : m_st) | set;
      m_wb = desc_wb_en_i && (err_zr_p_i || err_zr_q_i);
      m_wbs = m_wb ? {1'b1, err_zr_q_i, err_zr_p_i} : 3'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s [%s] actual=%0h expected=%0h t=%0t", req, scen, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(status_o[0] == m_st[0], "R1 eot bit", status_o, m_st);
    chk(status_o[1] == m_st[1], "R2 eoc bit", status_o, m_st);
    chk(status_o[5:2] == m_st[5:2], "R5 error bits", status_o, m_st);
    chk(status_o[7:6] == m_st[7:6], "R7 zero-result bits", status_o, m_st);
    chk(active_o == m_act, "R11 active", active_o, m_act);
    chk(reread_o == m_rr, "R6 reread", reread_o, m_rr);
    chk({wb_req_o, wb_stat_o} == {m_wb, m_wbs}, "R7 writeback", {wb_req_o, wb_stat_o}, {m_wb, m_wbs});
    chk({irq_eot_o, irq_eoc_o, irq_err_o} == {m_st[0], m_st[1], |m_st[7:2]}, "R10 irq",
        {irq_eot_o, irq_eoc_o, irq_err_o}, {m_st[0], m_st[1], |m_st[7:2]});
  endtask

  // one cycle: inputs already driven, wait past the edge, compare, release pulses
  task automatic step();
    @(negedge clk);
    compare_all();
    chan_start_i = 0; desc_done_i = 0; reread_done_i = 0;
    err_parity_i = 0; err_mabort_i = 0; err_tabort_i = 0; err_mport_i = 0;
    err_zr_p_i = 0; err_zr_q_i = 0; sw_clr_we_i = 0; sw_clr_data_i = 0;
  endtask

  task automatic clear_all();
    sw_clr_we_i = 1; sw_clr_data_i = 8'hFF; step();
  endtask

  task automatic start();
    chan_start_i = 1; step();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    scen = "R11 reset";
    chk(status_o == 0 && !active_o && !irq_err_o && !wb_req_o, "R11 reset", status_o, 0);
    rst = 0;
    step();

    scen = "R12 idle events ignored";
    desc_irq_en_i = 1; desc_done_i = 1; next_ptr_i = 16'h40; step();
    chk(status_o[0] == 0, "R12 idle done", status_o, 0);
    reread_done_i = 1; next_ptr_i = 0; step();
    chk(status_o[1:0] == 0, "R12 idle reread", status_o, 0);

    scen = "R1/R13 end of transfer";
    start();
    desc_done_i = 1; next_ptr_i = 16'h80; step();
    chk(status_o[0] && active_o, "R13 eot latency", status_o, 1);

    scen = "R8 error over pending eot";
    err_mport_i = 1; step();
    chk(status_o == 8'h21 && !active_o, "R8 eot held", status_o, 8'h21);
    clear_all();

    scen = "R2 end of chain";
    start();
    desc_done_i = 1; next_ptr_i = 0; resume_i = 0; step();
    chk(status_o == 8'h02 && !active_o, "R2 eoc", status_o, 8'h02);
    clear_all();

    scen = "R3 no irq enable";
    desc_irq_en_i = 0; start();
    desc_done_i = 1; next_ptr_i = 16'h10; step();
    desc_done_i = 1; next_ptr_i = 0; step();
    chk(status_o == 0 && !active_o, "R3 flags off", status_o, 0);

    scen = "R6 resume at chain end";
    desc_irq_en_i = 1; start();
    desc_done_i = 1; next_ptr_i = 0; resume_i = 1; step();
    chk(reread_o && active_o && status_o == 8'h01, "R6 reread req", status_o, 8'h01);
    reread_done_i = 1; next_ptr_i = 16'h99; resume_i = 0; step();
    chk(active_o && status_o == 8'h01, "R6 appended", status_o, 8'h01);
    desc_done_i = 1; next_ptr_i = 0; resume_i = 1; step();
    reread_done_i = 1; resume_i = 0; step();
    chk(!active_o && status_o == 8'h03, "R6 null reread", status_o, 8'h03);
    clear_all();

    scen = "R4 error with completion";
    start();
    desc_done_i = 1; next_ptr_i = 16'h7; err_parity_i = 1; err_tabort_i = 1; step();
    chk(status_o == 8'h14 && !active_o, "R4 suppressed", status_o, 8'h14);

    scen = "R9 clear vs set";
    sw_clr_we_i = 1; sw_clr_data_i = 8'h14; err_parity_i = 1; step();
    chk(status_o == 8'h04, "R9 set wins", status_o, 8'h04);
    sw_clr_we_i = 1; sw_clr_data_i = 8'h04; step();
    chk(status_o == 0 && !irq_err_o, "R9 w1c", status_o, 0);

    scen = "R7 zero-result routing";
    start();
    desc_wb_en_i = 1; err_zr_p_i = 1; err_zr_q_i = 1; step();
    chk(wb_req_o && wb_stat_o == 3'b111 && status_o == 0 && !irq_err_o && active_o,
        "R7 writeback", wb_stat_o, 3'b111);
    desc_wb_en_i = 0; err_zr_q_i = 1; step();
    chk(status_o == 8'h80 && irq_err_o, "R7 register", status_o, 8'h80);
    clear_all();

    scen = "R5 random";
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      chan_start_i  = ($urandom_range(0, 9) == 0);
      desc_done_i   = (r < 25);
      reread_done_i = (r >= 25 && r < 33);
      next_ptr_i    = ($urandom_range(0, 2) == 0) ? '0 : PW'($urandom_range(1, 255));
      resume_i      = ($urandom_range(0, 3) == 0);
      desc_irq_en_i = ($urandom_range(0, 3) != 0);
      desc_wb_en_i  = $urandom_range(0, 1);
      err_parity_i  = ($urandom_range(0, 40) == 0);
      err_mabort_i  = ($urandom_range(0, 40) == 0);
      err_tabort_i  = ($urandom_range(0, 40) == 0);
      err_mport_i   = ($urandom_range(0, 40) == 0);
      err_zr_p_i    = ($urandom_range(0, 30) == 0);
      err_zr_q_i    = ($urandom_range(0, 30) == 0);
      sw_clr_we_i   = ($urandom_range(0, 5) == 0);
      sw_clr_data_i = 8'($urandom_range(0, 255));
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule